// File: doc/BRIEF.md
# Watchdog Timer with Gated System Reset

This block is a 32-bit down-counting watchdog that sits on a simple word-wide register bus. Software loads a count into the counter register to arm the watchdog and rewrites it periodically to keep it from expiring. While the run bit is set, the counter steps down by one on each count tick. The tick comes either from the local clock divided by a programmable power of two, or from an externally supplied fixed-rate strobe that is already synchronous to the local clock.

When the count steps from one to zero, the block sets a sticky expired flag and raises a level interrupt. The counter then stays at zero until it is reloaded. The system reset output is a registered signal. It is asserted only while the timer is expired and running, a reset-enable bit in its own register is set, and a reset-mask bit in another register is clear. This lets software arm the interrupt path without yet allowing the watchdog to reset the chip.

Top module: `wdt_core`

## Requirements
- R1: After reset, the reads at offsets 0x00, 0x04, 0x08 and 0x0C return 0, the counter at 0x34 reads 0xFFFFFFFF, and `irq_o` and `sys_rst_o` are low.
- R2: The counter changes only on ticks while the run bit (bit 8 of the control word at 0x00) is 1. While the run bit is 0, the count holds its value.
- R3: A write to 0x34 loads the written value, and the load takes priority over a tick in the same cycle. Each tick lowers the count by one, and a read of 0x34 returns the remaining count. Expiry happens on the tick that takes the count from 1 to 0.
- R4: After expiry the count stays at 0 until software writes 0x34.
- R5: Status bit 31 at 0x04 is set on expiry and stays set across reloads. Writing 0x04 with bit 31 equal to 0 clears it; a write with bit 31 equal to 1 leaves it unchanged.
- R6: `irq_o` is high exactly while the expired flag is set. It is visible in the same cycle as the flag and drops in the cycle the flag is cleared.
- R7: In divided mode (bit 10 = 0), the ratio field at bits [18:16] with value n gives one tick every 2^n clocks. The first decrement comes 2^n clocks after the write that sets the run bit. Reading 0x00 returns bits 8, 10 and [18:16] as written.
- R8: When bit 10 of the control word is 1, the counter steps only in cycles where `fixed_tick_i` is high.
- R9: `sys_rst_o` rises one clock after the count reaches 0 with the flag set, but only if the run bit is 1, the reset-enable bit (0x08 bit 8) is 1 and the mask bit (0x0C bit 10) is 0. Otherwise it stays low.
- R10: `sys_rst_o` falls one clock after any of these: the mask is set, the run bit is cleared, the flag is cleared, or the counter is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Bus access select |
| bus_wr_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| fixed_tick_i | input | 1 | Fixed-rate tick strobe, synchronous to clk |
| irq_o | output | 1 | Expiry interrupt level |
| sys_rst_o | output | 1 | Gated system reset request |

## Verification
Register writes act at the clock edge where the strobe is sampled. Reads are combinational and reflect the state after that edge. The count, the expired flag and `irq_o` change at the edge of the expiring tick. `sys_rst_o` follows its gating conditions one edge later. In divided mode, expiry comes 2^n × count edges after the enabling write.

Every expectation is queued with the exact cycle in which it falls due. The monitor samples at the falling edge of precisely that cycle. Each reset-output check therefore also confirms that the output does not change a cycle early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int RATIO_W   = 3;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RSTEN = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h34;

    // bit positions
    localparam int RUN_BIT   = 8;
    localparam int FIXED_BIT = 10;
    localparam int RATIO_LSB = 16;
    localparam int EXP_BIT   = 31;
    localparam int RSTEN_BIT = 8;
    localparam int MASK_BIT  = 10;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               fixed_sel;
        logic               run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.ratio     = w[RATIO_LSB +: RATIO_W];
        c.fixed_sel = w[FIXED_BIT];
        c.run       = w[RUN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RATIO_LSB +: RATIO_W] = c.ratio;
        w[FIXED_BIT]            = c.fixed_sel;
        w[RUN_BIT]              = c.run;
        return w;
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int RATIO_W = wdt_pkg::RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic               fixed_sel_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               fixed_tick_i,
    output logic               tick_o
);
    localparam int PRE_W = (1 << RATIO_W) - 1;
    localparam logic [PRE_W-1:0] ONE = 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    logic             div_hit;

    // 2^ratio - 1; wraps correctly for the largest ratio
    always_comb limit = (ONE << ratio_i) - ONE;
    assign div_hit = (pre_cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run_i)   pre_cnt <= '0;
        else if (div_hit)    pre_cnt <= '0;
        else                 pre_cnt <= pre_cnt + ONE;
    end

    assign tick_o = run_i && (fixed_sel_i ? fixed_tick_i : div_hit);

    // divided ticks with ratio >= 1 are never back to back (R7)
    assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !fixed_sel_i && ratio_i != '0)
            |=> (!tick_o || fixed_sel_i || ratio_i == '0));

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    always_ff @(posedge clk) begin
        if (rst)                         cnt_o <= CNT_MAX;
        else if (load_i)                 cnt_o <= load_val_i;
        else if (tick_i && !zero_o)      cnt_o <= cnt_o - CNT_ONE;
    end

    assign zero_o   = (cnt_o == '0);
    assign expire_o = tick_i && !load_i && (cnt_o == CNT_ONE);

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - CNT_ONE));

    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load_i) |=> zero_o);

    assert_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(cnt_o));

endmodule

// File: rtl/wdt_rst_gate.sv
module wdt_rst_gate (
    input  logic clk,
    input  logic rst,
    input  logic expired_i,
    input  logic cnt_zero_i,
    input  logic run_i,
    input  logic rst_en_i,
    input  logic mask_i,
    output logic sys_rst_o
);
    always_ff @(posedge clk) begin
        if (rst) sys_rst_o <= 1'b0;
        else     sys_rst_o <= expired_i && cnt_zero_i && run_i && rst_en_i && !mask_i;
    end

    assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        mask_i |=> !sys_rst_o);

    assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !sys_rst_o);

    assert_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        !rst_en_i |=> !sys_rst_o);

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = wdt_pkg::DATA_W,
    parameter int ADDR_W = wdt_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              fixed_tick_i,
    output logic              irq_o,
    output logic              sys_rst_o
);
    import wdt_pkg::*;

    ctrl_t            ctrl_q;
    logic             rst_en_q;
    logic             mask_q;
    logic             expired_q;
    logic             wr_en;
    logic             tick;
    logic             load;
    logic             cnt_zero;
    logic             expire;
    logic [CNT_W-1:0] cnt;
    logic             unused_wbits;

    assign wr_en = bus_sel_i && bus_wr_i;
    assign load  = wr_en && (bus_addr_i == OFS_COUNT);
    assign unused_wbits = ^bus_wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            rst_en_q <= 1'b0;
            mask_q   <= 1'b0;
        end else if (wr_en) begin
            case (bus_addr_i)
                OFS_CTRL:  ctrl_q   <= ctrl_from_word(bus_wdata_i);
                OFS_RSTEN: rst_en_q <= bus_wdata_i[RSTEN_BIT];
                OFS_MASK:  mask_q   <= bus_wdata_i[MASK_BIT];
                default: ;
            endcase
        end
    end

    // sticky flag: expiry wins over a clearing write in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            expired_q <= 1'b0;
        else if (expire)
            expired_q <= 1'b1;
        else if (wr_en && bus_addr_i == OFS_STAT && !bus_wdata_i[EXP_BIT])
            expired_q <= 1'b0;
    end

    wdt_tick_gen #(.RATIO_W(RATIO_W)) u_tick (
        .clk          (clk),
        .rst          (rst),
        .run_i        (ctrl_q.run),
        .fixed_sel_i  (ctrl_q.fixed_sel),
        .ratio_i      (ctrl_q.ratio),
        .fixed_tick_i (fixed_tick_i),
        .tick_o       (tick)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (bus_wdata_i[CNT_W-1:0]),
        .tick_i     (tick),
        .cnt_o      (cnt),
        .zero_o     (cnt_zero),
        .expire_o   (expire)
    );

    wdt_rst_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .expired_i  (expired_q),
        .cnt_zero_i (cnt_zero),
        .run_i      (ctrl_q.run),
        .rst_en_i   (rst_en_q),
        .mask_i     (mask_q),
        .sys_rst_o  (sys_rst_o)
    );

    assign irq_o = expired_q;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            case (bus_addr_i)
                OFS_CTRL:  bus_rdata_o = ctrl_to_word(ctrl_q);
                OFS_STAT:  bus_rdata_o[EXP_BIT]   = expired_q;
                OFS_RSTEN: bus_rdata_o[RSTEN_BIT] = rst_en_q;
                OFS_MASK:  bus_rdata_o[MASK_BIT]  = mask_q;
                OFS_COUNT: bus_rdata_o = DATA_W'(cnt);
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    // the flag only rises together with the counter reaching zero (R5)
    assert_set_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(expired_q) |-> cnt_zero);

    // reset request implies the interrupt was pending in the prior cycle (R9)
    assert_rst_after_flag_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> $past(irq_o));

endmodule

// File: tb/tb_wdt_core.sv
module tb_wdt_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fixed_tick = 1'b0;
    logic        irq;
    logic        sys_rst;

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_RSTEN = 8'h08,
                           A_MASK = 8'h0C, A_CNT = 8'h34;
    localparam logic [31:0] RUN = 32'h100, FIXED = 32'h400;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          q_due[$];
    int          q_what[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    wdt_core dut (
        .clk(clk), .rst(rst), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .fixed_tick_i(fixed_tick), .irq_o(irq), .sys_rst_o(sys_rst)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = q_due.size() - 1; i >= 0; i--) begin
            if (q_due[i] == cyc) begin
                logic [31:0] act;
                act = (q_what[i] == 0) ? bus_rdata :
                      (q_what[i] == 1) ? {31'b0, irq} : {31'b0, sys_rst};
                checks++;
                if (act !== q_exp[i]) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h (cycle %0d)",
                             q_tag[i], act, q_exp[i], cyc);
                end
                q_due.delete(i); q_what.delete(i); q_exp.delete(i); q_tag.delete(i);
            end
        end
    end

    task automatic expect_at(input int dly, input int what, input logic [31:0] e,
                             input string tag);
        q_due.push_back(cyc + dly);
        q_what.push_back(what);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        expect_at(0, 0, e, tag);
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_fixed();
        @(posedge clk); #1 fixed_tick = 1'b1;
        @(posedge clk); #1 fixed_tick = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        // R1 reset state
        expect_at(0, 1, 0, "R1 irq after reset");
        expect_at(0, 2, 0, "R1 sys_rst after reset");
        rd(A_CTRL, 0, "R1 ctrl");
        rd(A_STAT, 0, "R1 status");
        rd(A_RSTEN, 0, "R1 reset enable");
        rd(A_MASK, 0, "R1 mask");
        rd(A_CNT, 32'hFFFF_FFFF, "R1 count");
        idle(20);
        rd(A_CNT, 32'hFFFF_FFFF, "R2 stopped count holds");

        // R3 R4 R5 R6: basic run at ratio 0
        wr(A_CNT, 5);
        rd(A_CNT, 5, "R3 load value");
        wr(A_CTRL, RUN);
        expect_at(4, 1, 0, "R6 irq low before expiry");
        expect_at(5, 1, 1, "R6 irq at expiry");
        rd(A_CNT, 4, "R3 one decrement per tick");
        idle(10);
        rd(A_CNT, 0, "R4 holds at zero");
        rd(A_STAT, 32'h8000_0000, "R5 flag set");
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, 32'h8000_0000, "R5 write of 1 keeps flag");
        wr(A_STAT, 0);
        expect_at(0, 1, 0, "R6 irq drops with flag");
        rd(A_STAT, 0, "R5 flag cleared");

        // R9 R10: reset gating
        wr(A_RSTEN, RUN);
        wr(A_CNT, 3);
        expect_at(3, 2, 0, "R9 no reset before flag");
        expect_at(4, 2, 1, "R9 reset one cycle after expiry");
        idle(6);
        wr(A_MASK, FIXED);
        expect_at(0, 2, 1, "R10 mask takes one cycle");
        expect_at(1, 2, 0, "R10 mask blocks reset");
        idle(2);
        wr(A_MASK, 0);
        expect_at(0, 2, 0, "R9 still low at unmask edge");
        expect_at(1, 2, 1, "R9 reset after unmask");
        idle(2);
        wr(A_STAT, 0);
        expect_at(0, 2, 1, "R10 flag clear takes one cycle");
        expect_at(1, 2, 0, "R10 flag clear drops reset");
        idle(2);
        wr(A_CNT, 2);
        expect_at(3, 2, 1, "R9 reset on re-expiry");
        idle(5);
        wr(A_CNT, 32'h1000);
        expect_at(0, 2, 1, "R10 reload takes one cycle");
        expect_at(1, 2, 0, "R10 reload drops reset");
        rd(A_STAT, 32'h8000_0000, "R5 flag sticky across reload");
        wr(A_CNT, 1);
        expect_at(2, 2, 1, "R9 reset after kick expiry");
        idle(4);
        wr(A_CTRL, 0);
        expect_at(0, 2, 1, "R10 stop takes one cycle");
        expect_at(1, 2, 0, "R10 stop drops reset");
        idle(2);
        wr(A_STAT, 0);
        wr(A_RSTEN, 0);
        wr(A_CNT, 1);
        wr(A_CTRL, RUN);
        expect_at(1, 1, 1, "R6 irq without reset enable");
        expect_at(3, 2, 0, "R9 no reset when enable clear");
        idle(5);

        // R2: stopping freezes the count
        wr(A_STAT, 0);
        wr(A_CNT, 100);
        wr(A_CTRL, 0);
        idle(10);
        rd(A_CNT, 98, "R2 count frozen after stop");

        // R7: divide by 4
        wr(A_CNT, 3);
        wr(A_CTRL, RUN | (32'd2 << 16));
        expect_at(11, 1, 0, "R7 ratio 2 before expiry");
        expect_at(12, 1, 1, "R7 ratio 2 expiry");
        rd(A_CNT, 3, "R7 no tick before 4 clocks");
        rd(A_CTRL, 32'h0002_0100, "R7 ctrl readback");
        idle(15);
        wr(A_STAT, 0);
        wr(A_CTRL, 0);
        // R7: divide by 32
        wr(A_CNT, 2);
        wr(A_CTRL, RUN | (32'd5 << 16));
        expect_at(63, 1, 0, "R7 ratio 5 before expiry");
        expect_at(64, 1, 1, "R7 ratio 5 expiry");
        idle(70);
        wr(A_STAT, 0);
        wr(A_CTRL, 0);

        // R8: fixed tick source
        wr(A_CNT, 2);
        wr(A_CTRL, RUN | FIXED);
        idle(10);
        rd(A_CNT, 2, "R8 no count without fixed tick");
        rd(A_CTRL, 32'h0000_0500, "R8 ctrl readback");
        pulse_fixed();
        rd(A_CNT, 1, "R8 one step per fixed tick");
        pulse_fixed();
        expect_at(0, 1, 1, "R8 expiry on fixed tick");
        idle(3);

        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL pending expectations actual=%0d expected=0", q_due.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule